// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the target-side control path of a plug-and-play add-in card. It owns both a configuration register file and a local memory window. On every PCI clock it samples the framing, initiator-ready and ID-select lines, along with the multiplexed address/data bus and the command/byte-enable lines. From these it decides two things: whether a new transaction is a configuration access or a memory access, and whether the card is the one being addressed.

When the card is addressed, the block drives the device-select and target-ready lines low. It raises one read or write strobe per data transfer and presents a register index or a memory word address. These are taken from the captured address phase. When the transfer finishes, it parks both lines high for one clock before it releases their output enables.

When the card is not addressed, the block sits out the foreign transaction until the bus is idle again. Each one-bit output enable is meant to drive the tri-state buffer of its pad. The memory-window base comes from the card's base-address register, which lives outside this block.

Top module: `pci_target_fsm`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle with these outputs: `devsel_n`=1, `trdy_n`=1, `devsel_oe`=0, `trdy_oe`=0, all four strobes 0, `cfg_index`=0 and `mem_word`=0. This holds even when reset arrives during a data phase.
- R2: A clock edge that sees `frame_n`=0 while idle is the address phase. If `idsel`=1 at that edge and the command is configuration read (`cbe_n`=1010) with AD[1:0]=00, the card claims. The claim shows as `devsel_n`=`trdy_n`=0 in the second clock after the address phase, with `devsel_n` still high in the first clock. In every claimed clock where `irdy_n`=0, `cfg_rd` is high.
- R3: Configuration write (`cbe_n`=1011) under the same conditions as R2 is claimed the same way and pulses `cfg_wr` instead.
- R4: A configuration command with `idsel`=1 whose AD[1:0] is not 00 is not claimed.
- R5: With `idsel`=0, memory read (0110) or memory write (0111) is claimed when AD[31:WIN_LOG2] equals `bar_base`. It pulses `mem_rd` or `mem_wr` respectively.
- R6: A memory command whose upper address bits differ from `bar_base` is not claimed.
- R7: The card does not claim any of these: commands other than the four listed, a configuration command with `idsel`=0, or a memory command with `idsel`=1.
- R8: While claimed, `cfg_index` equals AD[7:2] and `mem_word` equals AD[WIN_LOG2-1:2` of the address phase. Both are held stable for the whole data phase.
- R9: A claimed clock with `irdy_n`=0 and `frame_n`=1 is the last transfer. In the next clock, `devsel_n` and `trdy_n` are 1 while both output enables remain 1. In the clock after that, both enables are 0.
- R10: While claimed, `devsel_n` and `trdy_n` stay low as long as `frame_n`=0 or `irdy_n`=1. A strobe is raised only in clocks with `irdy_n`=0, once per such clock.
- R11: After an unclaimed address phase, the outputs stay inactive until a clock samples both `frame_n`=1 and `irdy_n`=1. The very next address phase after that is decoded normally.
- R12: At most one of `cfg_rd`, `cfg_wr`, `mem_rd`, `mem_wr` is high in any clock. No strobe is high unless `devsel_n`=`trdy_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this slot |
| ad_in | input | ADDR_W | Address/data bus as received |
| cbe_n | input | 4 | Command (address phase) / byte enables |
| bar_base | input | ADDR_W-WIN_LOG2 | Memory window base from the base-address register |
| devsel_n | output | 1 | Device select, active low |
| devsel_oe | output | 1 | Output enable for the device-select pad |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Output enable for the target-ready pad |
| cfg_rd | output | 1 | Configuration register read strobe |
| cfg_wr | output | 1 | Configuration register write strobe |
| cfg_index | output | 6 | Configuration register index |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_word | output | WIN_LOG2-2 | Local memory word address |

## Verification
Some properties are checked on every clock: the strobes are mutually exclusive and never occur outside a claim; a claim always trails its address phase by two clocks; the end of a transfer is always followed by a parked-high clock before the enables drop; and the address outputs do not move during a claim. Other behaviours can only be shown by the directed scenarios. These are the command and ID-select decode, the type-0 bit test, the base compare, the exact strobe chosen, the values of the index and word address, wait states and multi-transfer bursts, the sit-out of foreign traffic, and reset during a data phase.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    localparam int CFG_IDX_W = 6;
    localparam int CMD_W     = 4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CFG_CHK = 3'd1,
        ST_ADR_CMP = 3'd2,
        ST_READ    = 3'd3,
        ST_WRITE   = 3'd4,
        ST_TURN    = 3'd5,
        ST_BUSY    = 3'd6
    } pcit_state_e;

    localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'b0110;
    localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;

    // Decoded view of the captured address phase.
    typedef struct packed {
        logic cfg_hit;   // config command with type-0 address bits
        logic mem_hit;   // memory command inside the window
        logic is_write;  // write direction of a supported command
        logic is_cfg;    // config command class
    } pcit_dec_t;

    function automatic logic cmd_is_cfg(input logic [CMD_W-1:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
    endfunction

    function automatic logic cmd_is_mem(input logic [CMD_W-1:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

    // Bit 0 separates read from write for all four supported commands.
    function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
        return c[0];
    endfunction

    function automatic logic st_is_data(input pcit_state_e s);
        return (s == ST_READ) || (s == ST_WRITE);
    endfunction

endpackage

// File: rtl/pcit_addr_latch.sv
module pcit_addr_latch
    import pcit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20,
    localparam int BASE_W  = ADDR_W - WIN_LOG2,
    localparam int WORD_W  = WIN_LOG2 - 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    ad_in,
    input  logic [CMD_W-1:0]     cbe_n,
    input  logic [BASE_W-1:0]    bar_base,
    output pcit_dec_t            dec,
    output logic [CFG_IDX_W-1:0] cfg_index,
    output logic [WORD_W-1:0]    mem_word
);

    logic [ADDR_W-1:0] cap_ad;
    logic [CMD_W-1:0]  cap_cmd;

    // Address phase capture; held until the next address phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ad  <= '0;
            cap_cmd <= '0;
        end else if (load) begin
            cap_ad  <= ad_in;
            cap_cmd <= cbe_n;
        end
    end

    logic type0;
    logic base_match;

    always_comb begin
        type0      = (cap_ad[1:0] == 2'b00);
        base_match = (cap_ad[ADDR_W-1:WIN_LOG2] == bar_base);
    end

    always_comb begin
        dec.is_cfg   = cmd_is_cfg(cap_cmd);
        dec.cfg_hit  = cmd_is_cfg(cap_cmd) && type0;
        dec.mem_hit  = cmd_is_mem(cap_cmd) && base_match;
        dec.is_write = cmd_is_write(cap_cmd);
    end

    assign cfg_index = cap_ad[CFG_IDX_W+1:2];
    assign mem_word  = cap_ad[WIN_LOG2-1:2];

endmodule

// File: rtl/pcit_fsm.sv
module pcit_fsm
    import pcit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic        cfg_hit,
    input  logic        mem_hit,
    input  logic        is_write,
    output pcit_state_e state,
    output logic        load
);

    pcit_state_e nxt;
    pcit_state_e claim_st;

    always_comb begin
        claim_st = is_write ? ST_WRITE : ST_READ;
        load     = (state == ST_IDLE) && !frame_n;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!frame_n)
                    nxt = idsel ? ST_CFG_CHK : ST_ADR_CMP;
            end
            ST_CFG_CHK: nxt = cfg_hit ? claim_st : ST_BUSY;
            ST_ADR_CMP: nxt = mem_hit ? claim_st : ST_BUSY;
            ST_READ, ST_WRITE: begin
                if (!irdy_n && frame_n)
                    nxt = ST_TURN;
            end
            ST_TURN: nxt = ST_IDLE;
            ST_BUSY: begin
                if (frame_n && irdy_n)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/pcit_drive.sv
module pcit_drive
    import pcit_pkg::*;
(
    input  pcit_state_e state,
    input  logic        irdy_n,
    input  logic        is_cfg,
    output logic        devsel_n,
    output logic        devsel_oe,
    output logic        trdy_n,
    output logic        trdy_oe,
    output logic        cfg_rd,
    output logic        cfg_wr,
    output logic        mem_rd,
    output logic        mem_wr
);

    logic claimed;
    logic driven;
    logic xfer;

    always_comb begin
        claimed   = st_is_data(state);
        driven    = claimed || (state == ST_TURN);
        xfer      = claimed && !irdy_n;

        devsel_n  = !claimed;
        trdy_n    = !claimed;
        devsel_oe = driven;
        trdy_oe   = driven;

        cfg_rd    = xfer && is_cfg  && (state == ST_READ);
        cfg_wr    = xfer && is_cfg  && (state == ST_WRITE);
        mem_rd    = xfer && !is_cfg && (state == ST_READ);
        mem_wr    = xfer && !is_cfg && (state == ST_WRITE);
    end

endmodule

// File: rtl/pci_target_fsm.sv
module pci_target_fsm
    import pcit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 20,
    localparam int BASE_W  = ADDR_W - WIN_LOG2,
    localparam int WORD_W  = WIN_LOG2 - 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic                 idsel,
    input  logic [ADDR_W-1:0]    ad_in,
    input  logic [CMD_W-1:0]     cbe_n,
    input  logic [BASE_W-1:0]    bar_base,
    output logic                 devsel_n,
    output logic                 devsel_oe,
    output logic                 trdy_n,
    output logic                 trdy_oe,
    output logic                 cfg_rd,
    output logic                 cfg_wr,
    output logic [CFG_IDX_W-1:0] cfg_index,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [WORD_W-1:0]    mem_word
);

    pcit_dec_t   dec;
    pcit_state_e state;
    logic        load;

    pcit_addr_latch #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2)
    ) latch_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ad_in     (ad_in),
        .cbe_n     (cbe_n),
        .bar_base  (bar_base),
        .dec       (dec),
        .cfg_index (cfg_index),
        .mem_word  (mem_word)
    );

    pcit_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .idsel    (idsel),
        .cfg_hit  (dec.cfg_hit),
        .mem_hit  (dec.mem_hit),
        .is_write (dec.is_write),
        .state    (state),
        .load     (load)
    );

    pcit_drive drive_i (
        .state     (state),
        .irdy_n    (irdy_n),
        .is_cfg    (dec.is_cfg),
        .devsel_n  (devsel_n),
        .devsel_oe (devsel_oe),
        .trdy_n    (trdy_n),
        .trdy_oe   (trdy_oe),
        .cfg_rd    (cfg_rd),
        .cfg_wr    (cfg_wr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

endmodule

// File: rtl/pcit_checker.sv
module pcit_checker #(
    parameter int WORD_W = 18,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              devsel_n,
    input logic              devsel_oe,
    input logic              trdy_n,
    input logic              trdy_oe,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [IDX_W-1:0]  cfg_index,
    input logic [WORD_W-1:0] mem_word
);

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({cfg_rd, cfg_wr, mem_rd, mem_wr}) <= 1);  // R12

    AST_STROBE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd || cfg_wr || mem_rd || mem_wr) |-> (!devsel_n && !trdy_n));  // R12

    AST_CLAIM_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0));  // R2

    AST_LAST_XFER_PARKS: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && devsel_oe && trdy_oe));  // R9

    AST_RELEASE_AFTER_PARK: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_oe) |-> ($past(devsel_n) && $past(trdy_n)));  // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && $past(!devsel_n)) |-> ($stable(mem_word) && $stable(cfg_index)));  // R8

endmodule

bind pci_target_fsm pcit_checker #(
    .WORD_W (WIN_LOG2 - 2),
    .IDX_W  (6)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .devsel_n  (devsel_n),
    .devsel_oe (devsel_oe),
    .trdy_n    (trdy_n),
    .trdy_oe   (trdy_oe),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .cfg_index (cfg_index),
    .mem_word  (mem_word)
);

// File: tb/pci_target_fsm_tb.sv
module pci_target_fsm_tb_top;

    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;
    localparam int WIN   = 20;

    localparam logic [3:0] STB_NONE = 4'b0000;
    localparam logic [3:0] STB_CRD  = 4'b1000;  // {cfg_rd,cfg_wr,mem_rd,mem_wr}
    localparam logic [3:0] STB_CWR  = 4'b0100;
    localparam logic [3:0] STB_MRD  = 4'b0010;
    localparam logic [3:0] STB_MWR  = 4'b0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic [11:0] base = 12'hA5C;
    logic        devsel_n, devsel_oe, trdy_n, trdy_oe;
    logic        cfg_rd, cfg_wr, mem_rd, mem_wr;
    logic [5:0]  cfg_index;
    logic [17:0] mem_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pci_target_fsm #(.ADDR_W(32), .WIN_LOG2(WIN)) dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .ad_in(ad), .cbe_n(cbe_n), .bar_base(base),
        .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_index(cfg_index),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "devsel_n", {31'd0, devsel_n}, 1);
        chk(req, "trdy_n", {31'd0, trdy_n}, 1);
        chk(req, "enables", {30'd0, devsel_oe, trdy_oe}, 0);
        chk({req, " R12"}, "strobes", {28'd0, cfg_rd, cfg_wr, mem_rd, mem_wr}, 0);
    endtask

    // One transaction: address phase, decode clock, data clocks, exit.
    task automatic run_txn(input string req, input logic sel, input logic [3:0] cmd,
                           input logic [31:0] addr, input int waits, input int extra,
                           input logic claim, input logic [3:0] stb);
        @(posedge clk); #Q;
        frame_n = 0; idsel = sel; ad = addr; cbe_n = cmd; irdy_n = 1;
        @(posedge clk); #Q;
        idsel = 0; ad = 32'h1357_9BDF; cbe_n = 4'h0;
        irdy_n = (waits > 0); frame_n = (waits + extra == 0);
        @(negedge clk);
        chk({req, " R2 decode clock"}, "devsel_n", {31'd0, devsel_n}, 1);
        for (int i = 0; i < waits + extra + 1; i++) begin
            @(posedge clk); #Q;
            irdy_n  = (i < waits);
            frame_n = (i >= waits + extra);
            @(negedge clk);
            if (claim) begin
                chk({req, " R10"}, "devsel_n", {31'd0, devsel_n}, 0);
                chk({req, " R10"}, "trdy_n", {31'd0, trdy_n}, 0);
                chk({req, " R9"}, "enables", {30'd0, devsel_oe, trdy_oe}, 3);
                chk({req, " R12"}, "strobes", {28'd0, cfg_rd, cfg_wr, mem_rd, mem_wr},
                    {28'd0, (irdy_n ? STB_NONE : stb)});
                chk({req, " R8"}, "cfg_index", {26'd0, cfg_index}, {26'd0, addr[7:2]});
                chk({req, " R8"}, "mem_word", {14'd0, mem_word}, {14'd0, addr[WIN-1:2]});
            end else begin
                chk_idle({req, " R11"});
            end
        end
        @(posedge clk); #Q;
        irdy_n = 1; frame_n = 1;
        @(negedge clk);
        if (claim) begin
            chk({req, " R9 park"}, "devsel_n/trdy_n", {30'd0, devsel_n, trdy_n}, 3);
            chk({req, " R9 park"}, "enables", {30'd0, devsel_oe, trdy_oe}, 3);
            chk({req, " R12"}, "strobes", {28'd0, cfg_rd, cfg_wr, mem_rd, mem_wr}, 0);
        end else begin
            chk_idle({req, " R11 busy"});
        end
        @(posedge clk); #Q;
        @(negedge clk);
        chk_idle({req, " R9 release"});
    endtask

    task automatic t_reset_start();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1 reset");
        chk("R1 reset", "cfg_index", {26'd0, cfg_index}, 0);
        chk("R1 reset", "mem_word", {14'd0, mem_word}, 0);
        @(posedge clk); #Q; rst = 0;
    endtask

    task automatic t_reset_mid();
        @(posedge clk); #Q;
        frame_n = 0; idsel = 0; ad = 32'hA5C0_0ABC; cbe_n = 4'b0111; irdy_n = 1;
        @(posedge clk); #Q;
        frame_n = 0; irdy_n = 1;
        @(posedge clk); #Q;
        @(negedge clk);
        chk("R1 mid setup", "devsel_n", {31'd0, devsel_n}, 0);
        @(posedge clk); #Q; rst = 1;
        @(posedge clk); #Q;
        @(negedge clk);
        chk_idle("R1 mid-phase reset");
        chk("R1 mid-phase reset", "mem_word", {14'd0, mem_word}, 0);
        frame_n = 1; irdy_n = 1;
        @(posedge clk); #Q; rst = 0;
    endtask

    initial begin
        t_reset_start();
        run_txn("R2 cfg read",      1, 4'b1010, 32'h0000_0024, 0, 0, 1, STB_CRD);
        run_txn("R3 cfg write",     1, 4'b1011, 32'h0000_00FC, 0, 0, 1, STB_CWR);
        run_txn("R4 cfg AD01",      1, 4'b1010, 32'h0000_0025, 0, 0, 0, STB_NONE);
        run_txn("R4 cfg AD10",      1, 4'b1011, 32'h0000_0012, 0, 0, 0, STB_NONE);
        run_txn("R5 mem read",      0, 4'b0110, 32'hA5C1_2344, 0, 0, 1, STB_MRD);
        run_txn("R5 mem write wait",0, 4'b0111, 32'hA5CF_FFFC, 2, 0, 1, STB_MWR);
        run_txn("R6 base mismatch", 0, 4'b0110, 32'hA5D0_0000, 0, 0, 0, STB_NONE);
        run_txn("R7 io read",       0, 4'b0010, 32'hA5C0_0000, 0, 0, 0, STB_NONE);
        run_txn("R7 cfg no idsel",  0, 4'b1010, 32'hA5C0_0000, 0, 0, 0, STB_NONE);
        run_txn("R7 mem with idsel",1, 4'b0110, 32'hA5C0_0000, 0, 0, 0, STB_NONE);
        run_txn("R10 burst write",  0, 4'b0111, 32'hA5C0_0100, 1, 2, 1, STB_MWR);
        run_txn("R11 foreign burst",0, 4'b0111, 32'h0000_1000, 1, 3, 0, STB_NONE);
        run_txn("R11 next claimed", 1, 4'b1010, 32'h0000_0040, 0, 0, 1, STB_CRD);
        t_reset_mid();
        run_txn("R1 after reset",   0, 4'b0110, 32'hA5C0_0008, 0, 0, 1, STB_MRD);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule